// File: doc/BRIEF.md
# Shared-Bus Accumulator Datapath

This block is the register-transfer core of a small accumulator machine. Eight registers and an internal word memory exchange values over one internal bus. A 3-bit source code picks which register or memory word drives that bus. Each destination captures the bus value when its load control is raised. The address and program counters can also count up, and the address, program counter and accumulator can be cleared. The address register always supplies the memory address.

The controls can be driven cycle by cycle from outside. Two built-in sequences do the common work. An instruction fetch copies the program counter into the address register and then moves the addressed memory word into the instruction register while the program counter advances. An I/O transfer moves the input register through the ALU into the accumulator and then copies the accumulator to the output register. A decoder on the instruction register reports the addressing mode flag.

Top module: `cbd_datapath`

## Requirements
- R1: After reset, the address, program counter, data, accumulator, instruction, temporary, input and output registers are all zero, and the sequencer is idle (`seq_busy` low).
- R2: `bus_sel` selects the bus source. The codes are 0 = zero, 1 = address register, 2 = program counter, 3 = data register, 4 = accumulator, 5 = instruction register, 6 = temporary register and 7 = memory word at the address register. The 12-bit sources are zero-extended to 16 bits.
- R3: `ld_en` bit k, for k from 1 to 6, loads the register with source code k from the bus at the clock edge. Bit 0 loads the output register, and bit 7 writes the bus value into memory at the address register. The address register and program counter take the low 12 bits of the bus.
- R4: Clear beats load, and load beats increment. `inc_en` bit 0 counts the address register and bit 1 counts the program counter. `clr_en` bits 0, 1 and 2 clear the address register, program counter and accumulator. Counting wraps from 0xFFF to 0x000.
- R5: The memory word at a newly loaded address is on the bus (code 7) in the cycle after the address register loads. A word written to memory reads back at once.
- R6: A `start_fetch` in an idle cycle starts a fetch. In the next cycle the program counter is copied into the address register. In the cycle after that, the memory word moves into the instruction register and the program counter increments. No register ever receives two operations in the same cycle.
- R7: `in_ld` captures `in_data` into the input register. A `start_io` in an idle cycle starts a transfer. In the next cycle the accumulator takes the input register through the ALU. In the cycle after that, the output register takes the accumulator.
- R8: `seq_busy` is high for the two cycles of each sequence. If both starts arrive together, the fetch wins and the I/O start is dropped. Starts that arrive while busy are ignored.
- R9: While `seq_busy` is high, the external `bus_sel`, `ld_en`, `inc_en`, `clr_en` and `alu_in` have no effect.
- R10: `ind_mode` equals bit 15 of the instruction register (1 = indirect).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 3 | External bus source code |
| ld_en | input | 8 | External load strobes, indexed by source code (0 output, 7 memory write) |
| inc_en | input | 2 | Count strobes: 0 address register, 1 program counter |
| clr_en | input | 3 | Clear strobes: 0 address register, 1 program counter, 2 accumulator |
| alu_in | input | 1 | Load accumulator from input register through the ALU |
| in_ld | input | 1 | Capture in_data into the input register |
| in_data | input | 16 | Input device word |
| start_fetch | input | 1 | Start instruction fetch sequence |
| start_io | input | 1 | Start input-to-output transfer sequence |
| bus_q | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| ir_q | output | 16 | Instruction register |
| ac_q | output | 16 | Accumulator |
| out_q | output | 16 | Output register |
| ind_mode | output | 1 | Addressing mode flag of the instruction |
| seq_busy | output | 1 | Sequencer active |

## Verification
The hardest situation to reach from the ports is a fetch that reads a known word at a chosen address. No port writes memory or the program counter directly. The stimulus therefore first builds state over the bus. It passes each value through the input register and the ALU into the accumulator, puts the accumulator on the bus to set the address register and write memory, and then loads the program counter the same way. Conflicting external strobes are driven during the busy cycles to show that they are ignored.

// File: rtl/cbd_pkg.sv
`timescale 1ns/1ps
// Shared types for the shared-bus datapath: bus source codes, control bundle
// and sequencer states. Assumes an eight-way bus with fixed source codes.
package cbd_pkg;

    typedef enum logic [2:0] {
        SRC_ZERO = 3'd0,
        SRC_AR   = 3'd1,
        SRC_PC   = 3'd2,
        SRC_DR   = 3'd3,
        SRC_AC   = 3'd4,
        SRC_IR   = 3'd5,
        SRC_TR   = 3'd6,
        SRC_MEM  = 3'd7
    } bus_src_e;

    localparam int LD_OUT = 0;   // ld bit 0 targets the output register
    localparam int LD_MEM = 7;   // ld bit 7 writes memory
    localparam int CNT_AR = 0;
    localparam int CNT_PC = 1;
    localparam int CLR_AR = 0;
    localparam int CLR_PC = 1;
    localparam int CLR_AC = 2;

    typedef struct packed {
        bus_src_e    sel;
        logic [7:0]  ld;
        logic [1:0]  inc;
        logic [2:0]  clr;
        logic        alu_in;
    } ctl_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_F1,
        SQ_F2,
        SQ_IO1,
        SQ_IO2
    } seq_st_e;

endpackage

// File: rtl/cbd_reg.sv
`timescale 1ns/1ps
// Generic datapath register with clear, load and increment.
// Assumes priority clear > load > increment; increment wraps at W bits.
module cbd_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic         inc,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] nxt;

    // Pick the next value by control priority.
    always_comb begin
        nxt = q;
        if (clr)
            nxt = '0;
        else if (ld)
            nxt = d;
        else if (inc)
            nxt = q + W'(1);
    end

    // Hold the register state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= nxt;
    end

endmodule

// File: rtl/cbd_bus_mux.sv
`timescale 1ns/1ps
// Eight-way bus source multiplexer. Narrow address-width sources are
// zero-extended. Assumes DW > AW.
module cbd_bus_mux
    import cbd_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  bus_src_e      sel,
    input  logic [AW-1:0] ar,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] dr,
    input  logic [DW-1:0] ac,
    input  logic [DW-1:0] ir,
    input  logic [DW-1:0] tr,
    input  logic [DW-1:0] mem,
    output logic [DW-1:0] bus
);

    localparam int PAD = DW - AW;

    // Route the selected source onto the bus.
    always_comb begin
        unique case (sel)
            SRC_AR:  bus = {{PAD{1'b0}}, ar};
            SRC_PC:  bus = {{PAD{1'b0}}, pc};
            SRC_DR:  bus = dr;
            SRC_AC:  bus = ac;
            SRC_IR:  bus = ir;
            SRC_TR:  bus = tr;
            SRC_MEM: bus = mem;
            default: bus = '0;
        endcase
    end

endmodule

// File: rtl/cbd_mem.sv
`timescale 1ns/1ps
// Word memory addressed by the address register. Writes happen at the
// clock edge. The read port follows the address combinationally, so a word
// is valid the cycle after the address register loads. No reset on contents.
module cbd_mem #(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store the bus word on a write strobe.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    // Present the addressed word.
    assign rdata = mem[addr];

endmodule

// File: rtl/cbd_sequencer.sv
`timescale 1ns/1ps
// Two-step sequencer for fetch and I/O transfer. Passes external controls
// through when idle and replaces them completely while a sequence runs.
// Assumes fetch has priority when both starts coincide.
module cbd_sequencer
    import cbd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_fetch,
    input  logic start_io,
    input  ctl_t man,
    output ctl_t eff,
    output logic busy
);

    seq_st_e st, st_nxt;

    // Advance through the sequence steps.
    always_comb begin
        st_nxt = SQ_IDLE;
        unique case (st)
            SQ_IDLE: begin
                if (start_fetch)
                    st_nxt = SQ_F1;
                else if (start_io)
                    st_nxt = SQ_IO1;
            end
            SQ_F1:   st_nxt = SQ_F2;
            SQ_IO1:  st_nxt = SQ_IO2;
            default: st_nxt = SQ_IDLE;
        endcase
    end

    // Hold the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= SQ_IDLE;
        else
            st <= st_nxt;
    end

    // Issue the micro-operations of the current step.
    always_comb begin
        eff = man;
        if (st != SQ_IDLE)
            eff = '0;
        unique case (st)
            SQ_F1: begin
                eff.sel             = SRC_PC;
                eff.ld[int'(SRC_AR)] = 1'b1;
            end
            SQ_F2: begin
                eff.sel             = SRC_MEM;
                eff.ld[int'(SRC_IR)] = 1'b1;
                eff.inc[CNT_PC]     = 1'b1;
            end
            SQ_IO1: eff.alu_in = 1'b1;
            SQ_IO2: begin
                eff.sel        = SRC_AC;
                eff.ld[LD_OUT] = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy = (st != SQ_IDLE);

endmodule

// File: rtl/cbd_datapath.sv
`timescale 1ns/1ps
// Shared-bus accumulator datapath top. Registers exchange values over one
// bus chosen by a 3-bit source code. The input register reaches the
// accumulator only through the ALU, which passes the input word through.
// Assumes DATA_W > ADDR_W.
module cbd_datapath
    import cbd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_sel,
    input  logic [7:0]        ld_en,
    input  logic [1:0]        inc_en,
    input  logic [2:0]        clr_en,
    input  logic              alu_in,
    input  logic              in_ld,
    input  logic [DATA_W-1:0] in_data,
    input  logic              start_fetch,
    input  logic              start_io,
    output logic [DATA_W-1:0] bus_q,
    output logic [ADDR_W-1:0] ar_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [DATA_W-1:0] ir_q,
    output logic [DATA_W-1:0] ac_q,
    output logic [DATA_W-1:0] out_q,
    output logic              ind_mode,
    output logic              seq_busy
);

    localparam int MODE_BIT = DATA_W - 1;

    ctl_t              man, eff;
    logic [DATA_W-1:0] dr_q, tr_q, in_q, mem_q, alu_y, ac_d;

    // Bundle the external controls.
    always_comb begin
        man.sel    = bus_src_e'(bus_sel);
        man.ld     = ld_en;
        man.inc    = inc_en;
        man.clr    = clr_en;
        man.alu_in = alu_in;
    end

    cbd_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .start_fetch(start_fetch),
        .start_io(start_io), .man(man), .eff(eff), .busy(seq_busy)
    );

    cbd_bus_mux #(.DW(DATA_W), .AW(ADDR_W)) u_mux (
        .sel(eff.sel), .ar(ar_q), .pc(pc_q), .dr(dr_q), .ac(ac_q),
        .ir(ir_q), .tr(tr_q), .mem(mem_q), .bus(bus_q)
    );

    cbd_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .clk(clk), .we(eff.ld[LD_MEM]), .addr(ar_q),
        .wdata(bus_q), .rdata(mem_q)
    );

    cbd_reg #(.W(ADDR_W)) u_ar (
        .clk(clk), .rst_n(rst_n), .clr(eff.clr[CLR_AR]),
        .ld(eff.ld[int'(SRC_AR)]), .inc(eff.inc[CNT_AR]),
        .d(bus_q[ADDR_W-1:0]), .q(ar_q)
    );

    cbd_reg #(.W(ADDR_W)) u_pc (
        .clk(clk), .rst_n(rst_n), .clr(eff.clr[CLR_PC]),
        .ld(eff.ld[int'(SRC_PC)]), .inc(eff.inc[CNT_PC]),
        .d(bus_q[ADDR_W-1:0]), .q(pc_q)
    );

    cbd_reg #(.W(DATA_W)) u_dr (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .ld(eff.ld[int'(SRC_DR)]), .inc(1'b0), .d(bus_q), .q(dr_q)
    );

    cbd_reg #(.W(DATA_W)) u_ir (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .ld(eff.ld[int'(SRC_IR)]), .inc(1'b0), .d(bus_q), .q(ir_q)
    );

    cbd_reg #(.W(DATA_W)) u_tr (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .ld(eff.ld[int'(SRC_TR)]), .inc(1'b0), .d(bus_q), .q(tr_q)
    );

    cbd_reg #(.W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .ld(eff.ld[LD_OUT]), .inc(1'b0), .d(bus_q), .q(out_q)
    );

    cbd_reg #(.W(DATA_W)) u_in (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .ld(in_ld), .inc(1'b0), .d(in_data), .q(in_q)
    );

    // ALU in transfer mode: the input word passes straight through.
    assign alu_y = in_q;

    // Accumulator source: ALU result on an ALU transfer, else the bus.
    assign ac_d = eff.alu_in ? alu_y : bus_q;

    cbd_reg #(.W(DATA_W)) u_ac (
        .clk(clk), .rst_n(rst_n), .clr(eff.clr[CLR_AC]),
        .ld(eff.alu_in | eff.ld[int'(SRC_AC)]), .inc(1'b0),
        .d(ac_d), .q(ac_q)
    );

    // Mode decoder: top instruction bit flags indirect addressing.
    assign ind_mode = ir_q[MODE_BIT];

endmodule

// File: rtl/cbd_datapath_checker.sv
`timescale 1ns/1ps
// Protocol checker for the shared-bus datapath, bound to the top module.
// Assumes the top's internal names in_q, tr_q and eff.
module cbd_datapath_checker
    import cbd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_fetch,
    input logic              start_io,
    input logic [7:0]        ld_en,
    input logic [2:0]        clr_en,
    input logic              seq_busy,
    input logic [DATA_W-1:0] bus_q,
    input logic [ADDR_W-1:0] ar_q,
    input logic [ADDR_W-1:0] pc_q,
    input logic [DATA_W-1:0] out_q,
    input logic [DATA_W-1:0] in_q,
    input logic [DATA_W-1:0] tr_q,
    input ctl_t              eff
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && ar_q == '0 && !seq_busy));

    assert_pc_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && ld_en[2] && !clr_en[1]) |=> pc_q == $past(bus_q[ADDR_W-1:0]));

    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && clr_en[1]) |=> pc_q == '0);

    assert_fetch_ar_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_fetch && !seq_busy) |=> ##1 (ar_q == $past(pc_q, 2)));

    assert_fetch_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_fetch && !seq_busy) |=> ##2 (pc_q == ADDR_W'($past(pc_q, 3) + 1'b1) && !seq_busy));

    assert_seq_no_conflict_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> ($countones({eff.ld[2], eff.inc[1], eff.clr[1]}) <= 1 &&
                      $countones({eff.ld[1], eff.inc[0], eff.clr[0]}) <= 1));

    assert_io_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_io && !start_fetch && !seq_busy) |=> ##2 (out_q == $past(in_q, 2)));

    assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_fetch || start_io) && !seq_busy) |=> seq_busy);

    assert_tr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> tr_q == $past(tr_q));

endmodule

bind cbd_datapath cbd_datapath_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_fetch(start_fetch), .start_io(start_io),
    .ld_en(ld_en), .clr_en(clr_en), .seq_busy(seq_busy), .bus_q(bus_q),
    .ar_q(ar_q), .pc_q(pc_q), .out_q(out_q), .in_q(in_q), .tr_q(tr_q), .eff(eff)
);

// File: tb/cbd_datapath_bench.sv
`timescale 1ns/1ps
// Directed bench for the shared-bus datapath: one task per scenario.
module cbd_datapath_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic [7:0]  ld_en = '0;
    logic [1:0]  inc_en = '0;
    logic [2:0]  clr_en = '0;
    logic        alu_in = 1'b0;
    logic        in_ld = 1'b0;
    logic [15:0] in_data = '0;
    logic        start_fetch = 1'b0;
    logic        start_io = 1'b0;
    logic [15:0] bus_q, ir_q, ac_q, out_q;
    logic [11:0] ar_q, pc_q;
    logic        ind_mode, seq_busy;

    int n_chk = 0;
    int n_err = 0;

    cbd_datapath u_cbd_datapath (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .ld_en(ld_en),
        .inc_en(inc_en), .clr_en(clr_en), .alu_in(alu_in), .in_ld(in_ld),
        .in_data(in_data), .start_fetch(start_fetch), .start_io(start_io),
        .bus_q(bus_q), .ar_q(ar_q), .pc_q(pc_q), .ir_q(ir_q), .ac_q(ac_q),
        .out_q(out_q), .ind_mode(ind_mode), .seq_busy(seq_busy)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One clock of stimulus, applied just after an edge and cleared after the next.
    task automatic op(input logic [2:0] s, input logic [7:0] ld, input logic [1:0] inc,
                      input logic [2:0] clr, input logic alu, input logic ild,
                      input logic [15:0] din, input logic sf, input logic si);
        bus_sel = s; ld_en = ld; inc_en = inc; clr_en = clr; alu_in = alu;
        in_ld = ild; in_data = din; start_fetch = sf; start_io = si;
        @(posedge clk); #1;
        bus_sel = '0; ld_en = '0; inc_en = '0; clr_en = '0; alu_in = 1'b0;
        in_ld = 1'b0; start_fetch = 1'b0; start_io = 1'b0;
    endtask

    task automatic idle();
        op(3'd0, 8'h00, 2'b00, 3'b000, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
    endtask

    task automatic put_ac(input logic [15:0] v);
        op(3'd0, 8'h00, 2'b00, 3'b000, 1'b0, 1'b1, v, 1'b0, 1'b0);
        op(3'd0, 8'h00, 2'b00, 3'b000, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
    endtask

    task automatic from_ac(input logic [7:0] ld);
        op(3'd4, ld, 2'b00, 3'b000, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
    endtask

    task automatic set_ar(input logic [15:0] v);
        put_ac(v); from_ac(8'h02);
    endtask

    task automatic set_pc(input logic [15:0] v);
        put_ac(v); from_ac(8'h04);
    endtask

    task automatic wr_mem(input logic [15:0] a, input logic [15:0] d);
        set_ar(a); put_ac(d); from_ac(8'h80);
    endtask

    task automatic peek(input logic [2:0] s, output logic [15:0] v);
        bus_sel = s; #1; v = bus_q; bus_sel = '0; #1;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        peek(3'd0, v);
        chk("R1 bus", v, 16'h0);
        chk("R1 ar", {4'h0, ar_q}, 16'h0);
        chk("R1 pc", {4'h0, pc_q}, 16'h0);
        chk("R1 ir", ir_q, 16'h0);
        chk("R1 ac", ac_q, 16'h0);
        chk("R1 out", out_q, 16'h0);
        chk("R1 busy", {15'h0, seq_busy}, 16'h0);
    endtask

    task automatic t_bus_codes();
        logic [15:0] v;
        put_ac(16'h1234); from_ac(8'h08);          // data register
        put_ac(16'h00C0); from_ac(8'h40);          // temporary register
        put_ac(16'h8ABC); from_ac(8'h20);          // instruction register
        chk("R10 ind set", {15'h0, ind_mode}, 16'h1);
        set_ar(16'hFABC);
        set_pc(16'hF123);
        peek(3'd0, v); chk("R2 code0", v, 16'h0000);
        peek(3'd1, v); chk("R2 code1 zero-ext", v, 16'h0ABC);
        peek(3'd2, v); chk("R2 code2 zero-ext", v, 16'h0123);
        peek(3'd3, v); chk("R2 code3", v, 16'h1234);
        peek(3'd4, v); chk("R2 code4", v, 16'hF123);
        peek(3'd5, v); chk("R2 code5", v, 16'h8ABC);
        peek(3'd6, v); chk("R2 code6", v, 16'h00C0);
        put_ac(16'h0ABC); from_ac(8'h20);
        chk("R10 ind clear", {15'h0, ind_mode}, 16'h0);
        put_ac(16'h4321); from_ac(8'h01);
        chk("R3 output load", out_q, 16'h4321);
    endtask

    task automatic t_priority();
        set_pc(16'h0FFF);
        op(3'd0, 8'h00, 2'b10, 3'b000, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
        chk("R4 pc wrap", {4'h0, pc_q}, 16'h0000);
        put_ac(16'h0055);
        op(3'd4, 8'h04, 2'b10, 3'b000, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
        chk("R4 load over inc", {4'h0, pc_q}, 16'h0055);
        op(3'd4, 8'h04, 2'b10, 3'b010, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
        chk("R4 clear over load", {4'h0, pc_q}, 16'h0000);
        set_ar(16'h0010);
        op(3'd0, 8'h00, 2'b01, 3'b000, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
        chk("R4 ar inc", {4'h0, ar_q}, 16'h0011);
        op(3'd0, 8'h00, 2'b00, 3'b100, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
        chk("R4 ac clear over alu", ac_q, 16'h0000);
    endtask

    task automatic t_mem();
        logic [15:0] v;
        wr_mem(16'h0055, 16'hBEEF);
        wr_mem(16'h0056, 16'h1111);
        set_ar(16'h0055);
        peek(3'd7, v); chk("R5 read 055", v, 16'hBEEF);
        set_ar(16'h0056);
        peek(3'd7, v); chk("R5 read 056", v, 16'h1111);
        put_ac(16'h2222); from_ac(8'h80);
        peek(3'd7, v); chk("R5 write then read", v, 16'h2222);
    endtask

    task automatic t_fetch();
        logic [15:0] out0;
        wr_mem(16'h0020, 16'h8123);
        set_pc(16'h0020);
        put_ac(16'h7777);
        out0 = out_q;
        op(3'd0, 8'h00, 2'b00, 3'b000, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
        chk("R8 busy after start", {15'h0, seq_busy}, 16'h1);
        // external strobes during the busy cycle must be ignored
        op(3'd4, 8'h41, 2'b11, 3'b101, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
        chk("R6 ar from pc", {4'h0, ar_q}, 16'h0020);
        chk("R9 ac kept", ac_q, 16'h7777);
        chk("R9 out kept", out_q, out0);
        idle();
        chk("R6 ir from memory", ir_q, 16'h8123);
        chk("R6 pc advanced", {4'h0, pc_q}, 16'h0021);
        chk("R6 idle again", {15'h0, seq_busy}, 16'h0);
        chk("R10 fetched mode", {15'h0, ind_mode}, 16'h1);
    endtask

    task automatic t_io();
        op(3'd0, 8'h00, 2'b00, 3'b000, 1'b0, 1'b1, 16'h5A5A, 1'b0, 1'b1);
        op(3'd0, 8'h00, 2'b00, 3'b000, 1'b0, 1'b1, 16'h1234, 1'b0, 1'b0);
        chk("R7 ac via alu", ac_q, 16'h5A5A);
        idle();
        chk("R7 out from ac", out_q, 16'h5A5A);
        chk("R7 idle again", {15'h0, seq_busy}, 16'h0);
    endtask

    task automatic t_both_starts();
        set_pc(16'h0056);
        op(3'd0, 8'h00, 2'b00, 3'b000, 1'b0, 1'b0, 16'h0, 1'b1, 1'b1);
        op(3'd0, 8'h00, 2'b00, 3'b000, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
        idle();
        chk("R8 fetch wins", ir_q, 16'h2222);
        chk("R8 pc after fetch", {4'h0, pc_q}, 16'h0057);
        idle();
        chk("R8 no io run", out_q, 16'h5A5A);
        chk("R8 busy start ignored", {15'h0, seq_busy}, 16'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_bus_codes();
        t_priority();
        t_mem();
        t_fetch();
        t_io();
        t_both_starts();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule